// File: doc/BRIEF.md
# Multi-bank selectable clock divider

This block is the digital back end of a zero-delay clock buffer. It takes a high-rate clock from a frequency synthesizer, or a reference clock when the synthesizer is bypassed. It optionally halves that clock and feeds three banks of divided clock lines: five lines in bank A, four in bank B and two in bank C. Each bank chooses between two even ratios with a single select bit. All lines of one bank come from one divider register.

A single active-high master-reset input does two jobs. It clears every divider and drops the drive flag of every line, which models three-state outputs. Its release goes through a synchronizer clocked by the selected divider clock, so all banks start counting on the same edge and stay phase-aligned. Select inputs are static. They are changed only while the master reset is high.

Top module: `bank_clk_divider`

## Requirements
- R1: Bank A has 5 lines, bank B has 4 and bank C has 2. Every line of a bank carries the same value at all times.
- R2: Bank A divides its input clock by 4 when `sel_a` is 0 and by 6 when `sel_a` is 1.
- R3: Bank B divides its input clock by 4 when `sel_b` is 0 and by 2 when `sel_b` is 1.
- R4: Bank C divides its input clock by 2 when `sel_c` is 0 and by 4 when `sel_c` is 1.
- R5: With `pre_half` = 0 the banks count the selected clock directly. With `pre_half` = 1 they count every second edge of it, so every output period doubles.
- R6: With `bypass` = 1 the reference clock replaces the synthesizer clock as the divider input. With `bypass` = 0 the synthesizer clock is used.
- R7: While `mr_oe` is 1, every drive flag is 0 and every clock line is low. While `mr_oe` is 0, every drive flag is 1.
- R8: Every ratio gives a 50% duty cycle: the high time of each line is exactly half its period.
- R9: After `mr_oe` falls, all three banks produce their first rising edge on the same divider input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Synthesizer clock |
| ref_clk | input | 1 | Reference clock used in bypass |
| bypass | input | 1 | 1 selects the reference clock as divider input |
| pre_half | input | 1 | 1 enables the shared divide-by-2 ahead of the banks |
| sel_a | input | 1 | Bank A ratio select (0: /4, 1: /6) |
| sel_b | input | 1 | Bank B ratio select (0: /4, 1: /2) |
| sel_c | input | 1 | Bank C ratio select (0: /2, 1: /4) |
| mr_oe | input | 1 | Master reset and output disable, active high |
| qa | output | 5 | Bank A clock lines |
| qa_en | output | 5 | Bank A drive flags |
| qb | output | 4 | Bank B clock lines |
| qb_en | output | 4 | Bank B drive flags |
| qc | output | 2 | Bank C clock lines |
| qc_en | output | 2 | Bank C drive flags |

## Verification
All sixteen combinations of the three ratio selects and the pre-divide select are applied, first with the synthesizer clock and then with the reference clock. The two clocks have unrelated periods (10 and 14 time units), so a wrong divider-input mux shows up as a wrong absolute period. The ratio pairs differ per bank: A has 4/6, B has 4/2 and C has 2/4. An inverted or swapped select therefore gives a different period in at least one bank. Measuring high time next to period separates a correct count from a skewed toggle, and the divide-by-6 case is the one where an odd half-count would show. Each release of the master reset also checks that the three banks rise together and that the drive flags follow the reset input.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  // Width needed to count half of the largest supported ratio.
  function automatic int half_width(input int max_ratio);
    int w;
    w = 1;
    while ((1 << w) < (max_ratio / 2)) w++;
    return w;
  endfunction
endpackage

// File: rtl/cdiv_rst_sync.sv
module cdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign run = sh_q[STAGES-1];
endmodule

// File: rtl/cdiv_prediv.sv
module cdiv_prediv (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic halve,
  output logic ce
);
  logic tgl_q, tgl_d;

  always_comb tgl_d = run ? ~tgl_q : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_q <= 1'b0;
    else        tgl_q <= tgl_d;
  end

  assign ce = ~halve | tgl_q;

  // R5: when halving, no two consecutive enabled edges
  a_r5_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (run && halve && ce) |=> !ce);
endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank #(
  parameter int RATIO0 = 4,
  parameter int RATIO1 = 6,
  parameter int CW     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ce,
  input  logic sel,
  output logic q
);
  localparam logic [CW-1:0] HALF0 = CW'(RATIO0 / 2);
  localparam logic [CW-1:0] HALF1 = CW'(RATIO1 / 2);

  logic [CW-1:0] cnt_q, cnt_d, half;
  logic          q_q, q_d;

  always_comb begin
    half  = sel ? HALF1 : HALF0;
    cnt_d = cnt_q;
    q_d   = q_q;
    if (run && ce) begin
      if (cnt_q == '0) q_d = ~q_q;
      cnt_d = (cnt_q == half - 1'b1) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      q_q   <= q_d;
    end
  end

  assign q = q_q;

  // R8: output only moves on an enabled edge
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && ce)) |=> $stable(q_q));
  // R8: counter never reaches the half ratio
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < half);
  // R9: counting starts from a cleared divider
  a_r9_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0 && !q_q));
endmodule

// File: rtl/bank_clk_divider.sv
module bank_clk_divider #(
  parameter int A_LINES = 5,
  parameter int B_LINES = 4,
  parameter int C_LINES = 2,
  parameter int A_R0 = 4, parameter int A_R1 = 6,
  parameter int B_R0 = 4, parameter int B_R1 = 2,
  parameter int C_R0 = 2, parameter int C_R1 = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               src_clk,
  input  logic               ref_clk,
  input  logic               bypass,
  input  logic               pre_half,
  input  logic               sel_a,
  input  logic               sel_b,
  input  logic               sel_c,
  input  logic               mr_oe,
  output logic [A_LINES-1:0] qa,
  output logic [A_LINES-1:0] qa_en,
  output logic [B_LINES-1:0] qb,
  output logic [B_LINES-1:0] qb_en,
  output logic [C_LINES-1:0] qc,
  output logic [C_LINES-1:0] qc_en
);
  import cdiv_pkg::*;

  localparam int MAX_R = 6;
  localparam int CW    = half_width(MAX_R);

  logic div_clk, rst_n, run, ce;
  logic a_q, b_q, c_q;

  // Static select: plain mux in front of the whole divider tree
  assign div_clk = bypass ? ref_clk : src_clk;
  assign rst_n   = ~mr_oe;

  cdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(div_clk), .rst_n(rst_n), .run(run));

  cdiv_prediv u_pre (
    .clk(div_clk), .rst_n(rst_n), .run(run), .halve(pre_half), .ce(ce));

  cdiv_bank #(.RATIO0(A_R0), .RATIO1(A_R1), .CW(CW)) u_bank_a (
    .clk(div_clk), .rst_n(rst_n), .run(run), .ce(ce), .sel(sel_a), .q(a_q));
  cdiv_bank #(.RATIO0(B_R0), .RATIO1(B_R1), .CW(CW)) u_bank_b (
    .clk(div_clk), .rst_n(rst_n), .run(run), .ce(ce), .sel(sel_b), .q(b_q));
  cdiv_bank #(.RATIO0(C_R0), .RATIO1(C_R1), .CW(CW)) u_bank_c (
    .clk(div_clk), .rst_n(rst_n), .run(run), .ce(ce), .sel(sel_c), .q(c_q));

  assign qa    = {A_LINES{a_q}};
  assign qb    = {B_LINES{b_q}};
  assign qc    = {C_LINES{c_q}};
  assign qa_en = {A_LINES{rst_n}};
  assign qb_en = {B_LINES{rst_n}};
  assign qc_en = {C_LINES{rst_n}};
endmodule

// File: tb/tb_bank_clk_divider.sv
module tb_bank_clk_divider;
  localparam int TSRC = 10;
  localparam int TREF = 14;

  logic src_clk, ref_clk, bypass, pre_half, sel_a, sel_b, sel_c, mr_oe;
  logic [4:0] qa, qa_en;
  logic [3:0] qb, qb_en;
  logic [1:0] qc, qc_en;

  int n_chk, n_bad;
  bit done;
  int exp_q[$];

  bank_clk_divider dut (
    .src_clk(src_clk), .ref_clk(ref_clk), .bypass(bypass), .pre_half(pre_half),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .mr_oe(mr_oe),
    .qa(qa), .qa_en(qa_en), .qb(qb), .qb_en(qb_en), .qc(qc), .qc_en(qc_en));

  initial begin src_clk = 0; forever #(TSRC/2) src_clk = ~src_clk; end
  initial begin ref_clk = 0; forever #(TREF/2) ref_clk = ~ref_clk; end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // R1: each bank is all zeros or all ones
  task automatic check_uniform();
    check("R1 bank A uniform", int'(qa == 5'h00 || qa == 5'h1f), 1);
    check("R1 bank B uniform", int'(qb == 4'h0 || qb == 4'hf), 1);
    check("R1 bank C uniform", int'(qc == 2'h0 || qc == 2'h3), 1);
  endtask

  task automatic wait_rise(input int bank);
    case (bank)
      0: @(posedge qa[0]);
      1: @(posedge qb[0]);
      default: @(posedge qc[0]);
    endcase
  endtask

  task automatic wait_fall(input int bank);
    case (bank)
      0: @(negedge qa[0]);
      1: @(negedge qb[0]);
      default: @(negedge qc[0]);
    endcase
  endtask

  // Driver side: expected periods from the ratio rules R2..R6
  task automatic push_expected(input bit byp, input bit ph, input bit sa,
                               input bit sb, input bit sc);
    int t, m;
    t = byp ? TREF : TSRC;
    m = ph ? 2 : 1;
    exp_q.push_back((sa ? 6 : 4) * m * t);
    exp_q.push_back((sb ? 2 : 4) * m * t);
    exp_q.push_back((sc ? 4 : 2) * m * t);
  endtask

  // Monitor side: measure one bank and compare with the queue head
  task automatic measure(input int bank, input string req);
    time t0, tf, t1;
    int exp;
    wait_rise(bank); t0 = $time;
    wait_fall(bank); tf = $time;
    wait_rise(bank); t1 = $time;
    #1;
    check_uniform();
    exp = exp_q.pop_front();
    check({req, " period"}, int'(t1 - t0), exp);
    check("R8 duty", int'(tf - t0), exp / 2);
  endtask

  task automatic run_cfg(input bit byp, input bit ph, input bit sa,
                         input bit sb, input bit sc);
    mr_oe = 1;
    #(3 * TREF + 3);
    bypass = byp; pre_half = ph; sel_a = sa; sel_b = sb; sel_c = sc;
    #(3 * TREF + 1);
    check("R7 disabled qa_en", int'(qa_en), 0);
    check("R7 disabled qc_en", int'(qc_en), 0);
    check("R7 low in reset", int'({qa, qb, qc}), 0);
    push_expected(byp, ph, sa, sb, sc);
    mr_oe = 0;
    #1;
    check("R7 enabled", int'({qa_en, qb_en, qc_en}), 11'h7ff);
    // R9: first rising edge shared by all banks
    @(posedge qa[0]);
    #1;
    check("R9 aligned first edge", int'({qa[0], qb[0], qc[0]}), 3'b111);
    measure(0, byp ? "R2 R6 bank A" : "R2 bank A");
    measure(1, ph ? "R3 R5 bank B" : "R3 bank B");
    measure(2, "R4 bank C");
  endtask

  initial begin
    #(TSRC * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    mr_oe = 1; bypass = 0; pre_half = 0; sel_a = 0; sel_b = 0; sel_c = 0;
    #(5 * TSRC + 2);
    // Reset state
    check("R7 reset drive flags", int'({qa_en, qb_en, qc_en}), 0);
    check("R7 reset lines", int'({qa, qb, qc}), 0);
    for (int byp = 0; byp < 2; byp++)
      for (int cfg = 0; cfg < 16; cfg++)
        run_cfg(byp[0], cfg[3], cfg[2], cfg[1], cfg[0]);
    mr_oe = 1;
    #(2 * TREF);
    check("R7 final disable", int'({qa_en, qb_en, qc_en, qa, qb, qc}), 0);
    finish_run();
  end
endmodule